// File: doc/BRIEF.md
# Byte-Plane Fill and Copy Blitter

This block is a small memory-mapped drawing engine for a frame buffer that stores one byte per pixel. Software starts a command with two 32-bit bus writes. A write to an even word address (address bit 2 clear) holds a colour. A write to an odd word address (address bit 2 set) starts an operation. The destination pixel is taken from that write's address. The data word carries a source pixel address and a run length of 1 to 32 pixels. When the source field is all ones, the engine paints the run with the held colour. For any other source value, it copies the run byte by byte from the source address.

The pixel store is a single-port byte RAM inside the block. While the engine runs, it owns the RAM and performs one byte access per cycle. When the engine is idle, a direct pixel port on the same RAM lets the surrounding system load and inspect the frame buffer. The engine shows `busy` while it runs and raises `done` for one cycle when it finishes. A trigger that arrives while the engine is busy is dropped, and a sticky error flag records the event.

Top module: `pxblit_engine`

## Requirements
- R1: A bus write with address bit 2 equal to 0 stores the write data as the held colour, and only its low 8 bits are ever drawn. Such a write never starts an operation, and it is accepted even while the engine is busy.
- R2: A bus write with address bit 2 equal to 1 while idle starts an operation. The destination pixel is address bits [22:3] (20 bits). The source pixel is data bits [23:0]. The run length is data bits [28:24] plus one, which gives 1 to 32 pixels.
- R3: If the source field equals 0xFFFFFF, the operation is a fill. Each destination pixel receives the low byte of the colour that was held when the operation was triggered. A colour write during the run does not change that run.
- R4: For any other source value, the operation is a copy. For i running upward from 0 to length-1, the engine reads source pixel i and then writes it to destination pixel i. An overlapping forward copy therefore repeats already copied bytes.
- R5: Bus reads return 0 at all times.
- R6: `busy` rises in the cycle after the trigger write. It stays high for exactly length cycles for a fill and 2×length cycles for a copy.
- R7: `done` is high for exactly one cycle, namely the first cycle after `busy` falls.
- R8: A trigger write while `busy` is high is ignored and changes no pixel. It sets `err`, which then stays high until reset.
- R9: A destination pixel at or beyond DEPTH is not written, and the run does not wrap around. A source pixel at or beyond DEPTH reads as 0. The run's timing is the same either way.
- R10: After reset, `busy`, `done` and `err` are 0.
- R11: While the engine is idle, the pixel port writes `px_wdata` at `px_addr` when `px_en` and `px_we` are both high. With `px_en` high and `px_we` low, it returns the byte on `px_rdata` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 23 | Bus byte address (DST_BITS+3) |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, always 0 |
| busy | output | 1 | Engine running |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Sticky dropped-trigger flag |
| px_en | input | 1 | Pixel port access enable (idle only) |
| px_we | input | 1 | Pixel port write enable |
| px_addr | input | 10 | Pixel port address ($clog2(DEPTH)) |
| px_wdata | input | 8 | Pixel port write byte |
| px_rdata | output | 8 | Pixel port read byte, one cycle latency |

## Verification
The bound checker watches the control handshake on every cycle. It checks that a colour write never starts the engine and that a trigger while idle always does. It checks that each run lasts length or twice length cycles, according to the decoded mode. It also checks that `done` is a single-cycle pulse that follows `busy`, and that the error flag is set by a dropped trigger and then never clears. Only the bench scenarios can show pixel contents: fill colour and colour snapshot, copy order with overlap, masking at the RAM edge, source reads beyond the RAM, and that a dropped trigger leaves its target untouched. The bench reads those pixels back through the pixel port.

// File: rtl/pxblit_pkg.sv
package pxblit_pkg;
   localparam int SRC_W    = 24;
   localparam int LEN_W    = 5;
   localparam int PIX_W    = 8;
   localparam logic [SRC_W-1:0] FILL_KEY = '1;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FILL,
      ST_CRD,
      ST_CWR
   } blit_state_e;

   typedef struct packed {
      logic [SRC_W-1:0] src;
      logic [LEN_W-1:0] len_m1;
      logic [PIX_W-1:0] colour;
   } blit_cmd_t;
endpackage

// File: rtl/pxblit_cmd_reg.sv
module pxblit_cmd_reg
   import pxblit_pkg::*;
#(
   parameter int DST_BITS = 20,
   localparam int BUS_AW  = DST_BITS + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [BUS_AW-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   input  logic                busy,
   output logic                start,
   output logic                start_fill,
   output blit_cmd_t           cmd,
   output logic [DST_BITS-1:0] dst,
   output logic                err
);
   logic [PIX_W-1:0] colour_q;
   logic             trig;
   logic [4:0]       unused_bits;

   assign unused_bits = {bus_wdata[31:29], bus_addr[1:0]};
   assign trig        = bus_wr & bus_addr[2];
   assign start       = trig & ~busy;
   assign start_fill  = (bus_wdata[SRC_W-1:0] == FILL_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         colour_q <= '0;
         cmd      <= '0;
         dst      <= '0;
         err      <= 1'b0;
      end else begin
         if (bus_wr && !bus_addr[2])
            colour_q <= bus_wdata[PIX_W-1:0];
         if (start) begin
            cmd.src    <= bus_wdata[SRC_W-1:0];
            cmd.len_m1 <= bus_wdata[SRC_W+LEN_W-1:SRC_W];
            cmd.colour <= colour_q;
            dst        <= bus_addr[DST_BITS+2:3];
         end
         if (trig && busy)
            err <= 1'b1;
      end
   end
endmodule

// File: rtl/pxblit_seq.sv
module pxblit_seq
   import pxblit_pkg::*;
#(
   parameter int DST_BITS = 20,
   parameter int DEPTH    = 1024,
   localparam int RAM_AW  = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                start_fill,
   input  blit_cmd_t           cmd,
   input  logic [DST_BITS-1:0] dst,
   input  logic [PIX_W-1:0]    ram_q,
   output logic                busy,
   output logic                done,
   output logic                ram_en,
   output logic                ram_we,
   output logic [RAM_AW-1:0]   ram_addr,
   output logic [PIX_W-1:0]    ram_wdata
);
   blit_state_e          state;
   logic [LEN_W-1:0]     idx;
   logic                 src_ok_q;
   logic [DST_BITS:0]    dst_i;
   logic [SRC_W:0]       src_i;
   logic                 dst_ok, src_ok, last;

   assign dst_i  = {1'b0, dst} + (DST_BITS+1)'(idx);
   assign src_i  = {1'b0, cmd.src} + (SRC_W+1)'(idx);
   assign dst_ok = dst_i < (DST_BITS+1)'(DEPTH);
   assign src_ok = src_i < (SRC_W+1)'(DEPTH);
   assign last   = (idx == cmd.len_m1);
   assign busy   = (state != ST_IDLE);

   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = dst_i[RAM_AW-1:0];
      ram_wdata = cmd.colour;
      unique case (state)
         ST_FILL: begin
            ram_en = dst_ok;
            ram_we = 1'b1;
         end
         ST_CRD: begin
            ram_en   = src_ok;
            ram_addr = src_i[RAM_AW-1:0];
         end
         ST_CWR: begin
            ram_en    = dst_ok;
            ram_we    = 1'b1;
            ram_wdata = src_ok_q ? ram_q : '0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         src_ok_q <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               idx <= '0;
               if (start)
                  state <= start_fill ? ST_FILL : ST_CRD;
            end
            ST_FILL: begin
               if (last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_CRD: begin
               src_ok_q <= src_ok;
               state    <= ST_CWR;
            end
            ST_CWR: begin
               if (last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= ST_CRD;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pxblit_pixram.sv
module pxblit_pixram #(
   parameter int DEPTH   = 1024,
   parameter int WIDTH   = 8,
   localparam int RAM_AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [RAM_AW-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  q
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic             hit;

   generate
      if (DEPTH == (1 << RAM_AW)) begin : g_pow2
         assign hit = 1'b1;
      end else begin : g_guard
         assign hit = (32'(addr) < DEPTH);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (en && hit) begin
         if (we)
            mem[addr] <= wdata;
         else
            q <= mem[addr];
      end
   end
endmodule

// File: rtl/pxblit_engine.sv
module pxblit_engine
   import pxblit_pkg::*;
#(
   parameter int DST_BITS = 20,
   parameter int DEPTH    = 1024,
   localparam int BUS_AW  = DST_BITS + 3,
   localparam int RAM_AW  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   input  logic              px_en,
   input  logic              px_we,
   input  logic [RAM_AW-1:0] px_addr,
   input  logic [7:0]        px_wdata,
   output logic [7:0]        px_rdata
);
   if (DEPTH < 2 || DEPTH > (1 << DST_BITS)) begin : g_bad_depth
      $error("pxblit_engine: DEPTH must lie in 2..2**DST_BITS");
   end
   if (DST_BITS < 1 || DST_BITS > 24) begin : g_bad_dst
      $error("pxblit_engine: DST_BITS must lie in 1..24");
   end

   logic                start, start_fill;
   blit_cmd_t           cmd;
   logic [DST_BITS-1:0] dst;
   logic                eng_en, eng_we;
   logic [RAM_AW-1:0]   eng_addr;
   logic [PIX_W-1:0]    eng_wdata;
   logic                ram_en, ram_we;
   logic [RAM_AW-1:0]   ram_addr;
   logic [PIX_W-1:0]    ram_wdata, ram_q;
   logic                unused_rd;

   assign unused_rd = bus_rd;
   assign bus_rdata = '0;

   pxblit_cmd_reg #(.DST_BITS(DST_BITS)) u_cmd (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .busy(busy), .start(start),
      .start_fill(start_fill), .cmd(cmd), .dst(dst), .err(err)
   );

   pxblit_seq #(.DST_BITS(DST_BITS), .DEPTH(DEPTH)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_fill(start_fill),
      .cmd(cmd), .dst(dst), .ram_q(ram_q), .busy(busy), .done(done),
      .ram_en(eng_en), .ram_we(eng_we), .ram_addr(eng_addr),
      .ram_wdata(eng_wdata)
   );

   always_comb begin
      if (busy) begin
         ram_en    = eng_en;
         ram_we    = eng_we;
         ram_addr  = eng_addr;
         ram_wdata = eng_wdata;
      end else begin
         ram_en    = px_en;
         ram_we    = px_we;
         ram_addr  = px_addr;
         ram_wdata = px_wdata;
      end
   end

   pxblit_pixram #(.DEPTH(DEPTH), .WIDTH(PIX_W)) u_ram (
      .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
      .wdata(ram_wdata), .q(ram_q)
   );

   assign px_rdata = ram_q;
endmodule

// File: rtl/pxblit_engine_chk.sv
module pxblit_engine_chk #(
   parameter int BUS_AW = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              busy,
   input logic              done,
   input logic              err
);
   logic [6:0] run_cnt, run_exp;
   logic       trig_idle;

   assign trig_idle = bus_wr && bus_addr[2] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         run_exp <= '0;
      end else if (trig_idle) begin
         run_cnt <= '0;
         run_exp <= (7'(bus_wdata[28:24]) + 7'd1) << ((bus_wdata[23:0] == 24'hFFFFFF) ? 0 : 1);
      end else if (busy) begin
         run_cnt <= run_cnt + 7'd1;
      end
   end

   AST_COLOUR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr[2] && !busy) |=> !busy); // R1
   AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      trig_idle |=> busy); // R2
   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == run_exp)); // R6
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_ERR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[2] && busy) |=> err); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R8
endmodule

bind pxblit_engine pxblit_engine_chk #(.BUS_AW(BUS_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .busy(busy), .done(done), .err(err)
);

// File: tb/tb_pxblit_engine.sv
module tb_pxblit_engine;
   localparam int DEPTH = 1024;
   localparam int AW    = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [22:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        busy, done, err;
   logic        px_en = 0, px_we = 0;
   logic [AW-1:0] px_addr = '0;
   logic [7:0]  px_wdata = '0;
   logic [7:0]  px_rdata;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pxblit_engine #(.DST_BITS(20), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .err(err), .px_en(px_en), .px_we(px_we),
      .px_addr(px_addr), .px_wdata(px_wdata), .px_rdata(px_rdata)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int dst, input bit trig, input logic [31:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = 23'((dst << 3) | (trig ? 4 : 0));
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   function automatic logic [31:0] fill_word(input int len);
      return {3'b0, 5'(len - 1), 24'hFFFFFF};
   endfunction

   function automatic logic [31:0] copy_word(input int src, input int len);
      return {3'b0, 5'(len - 1), 24'(src)};
   endfunction

   task automatic px_write(input int a, input logic [7:0] d);
      @(negedge clk);
      px_en = 1; px_we = 1; px_addr = AW'(a); px_wdata = d;
      @(negedge clk);
      px_en = 0; px_we = 0;
   endtask

   task automatic px_read(input int a, output logic [7:0] d);
      @(negedge clk);
      px_en = 1; px_we = 0; px_addr = AW'(a);
      @(negedge clk);
      px_en = 0;
      d = px_rdata;
   endtask

   task automatic expect_px(input int a, input logic [7:0] e, input string req);
      logic [7:0] d;
      px_read(a, d);
      check(d === e, req, int'(d), int'(e));
   endtask

   // called at the negedge right after the trigger write
   task automatic wait_run(input int exp_cycles, input string req);
      int n = 0;
      while (busy === 1'b1) begin
         n++;
         @(negedge clk);
      end
      check(n == exp_cycles, req, n, exp_cycles);
      check(done === 1'b1, "R7 done after busy", int'(done), 1);
      @(negedge clk);
      check(done === 1'b0, "R7 done single cycle", int'(done), 0);
   endtask

   task automatic wait_idle();
      while (busy === 1'b1) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check(busy === 1'b0, "R10 busy", int'(busy), 0);
      check(done === 1'b0, "R10 done", int'(done), 0);
      check(err === 1'b0, "R10 err", int'(err), 0);
   endtask

   task automatic t_pixel_port();
      px_write(3, 8'h5A);
      px_write(4, 8'hC3);
      expect_px(3, 8'h5A, "R11 port rd 3");
      expect_px(4, 8'hC3, "R11 port rd 4");
   endtask

   task automatic t_colour_only();
      bus_write(0, 0, 32'hDEAD_BE11);
      check(busy === 1'b0, "R1 colour write no start", int'(busy), 0);
      bus_write(2, 0, 32'h0000_0011);
      check(busy === 1'b0, "R1 colour write odd dst no start", int'(busy), 0);
   endtask

   task automatic t_fill_basic();
      px_write(39, 8'h01);
      px_write(45, 8'h02);
      bus_write(0, 0, 32'h1234_56A5);
      bus_write(40, 1, fill_word(5));
      wait_run(5, "R6 fill duration 5");
      for (int i = 40; i < 45; i++) expect_px(i, 8'hA5, "R3 fill pixel");
      expect_px(39, 8'h01, "R2 fill start bound");
      expect_px(45, 8'h02, "R2 fill end bound");
   endtask

   task automatic t_fill_lengths();
      px_write(232, 8'h44);
      bus_write(0, 0, 32'h0000_0066);
      bus_write(200, 1, fill_word(32));
      wait_run(32, "R6 fill duration 32");
      expect_px(200, 8'h66, "R2 len32 first");
      expect_px(231, 8'h66, "R2 len32 last");
      expect_px(232, 8'h44, "R2 len32 beyond");
      px_write(251, 8'h10);
      bus_write(250, 1, fill_word(1));
      wait_run(1, "R6 fill duration 1");
      expect_px(250, 8'h66, "R2 len1 pixel");
      expect_px(251, 8'h10, "R2 len1 beyond");
   endtask

   task automatic t_copy();
      for (int i = 0; i < 7; i++) px_write(300 + i, 8'(8'h30 + i));
      px_write(507, 8'hEE);
      bus_write(500, 1, copy_word(300, 7));
      wait_run(14, "R6 copy duration 14");
      for (int i = 0; i < 7; i++) expect_px(500 + i, 8'(8'h30 + i), "R4 copy pixel");
      expect_px(507, 8'hEE, "R4 copy beyond");
   endtask

   task automatic t_overlap();
      for (int i = 0; i < 5; i++) px_write(600 + i, 8'(8'h11 * (i + 1)));
      bus_write(601, 1, copy_word(600, 4));
      wait_run(8, "R6 overlap duration");
      for (int i = 0; i < 5; i++) expect_px(600 + i, 8'h11, "R4 forward overlap");
   endtask

   task automatic t_colour_during_run();
      bus_write(0, 0, 32'h0000_00C1);
      bus_write(700, 1, fill_word(10));
      bus_write(0, 0, 32'h0000_00C2);
      wait_idle();
      for (int i = 700; i < 710; i++) expect_px(i, 8'hC1, "R3 snapshot colour");
      bus_write(720, 1, fill_word(2));
      wait_run(2, "R6 fill duration 2");
      expect_px(720, 8'hC2, "R1 colour accepted while busy");
   endtask

   task automatic t_drop_trigger();
      for (int i = 800; i < 804; i++) px_write(i, 8'h77);
      bus_write(0, 0, 32'h0000_0009);
      bus_write(760, 1, fill_word(20));
      bus_write(800, 1, fill_word(4));
      check(err === 1'b1, "R8 err set", int'(err), 1);
      wait_idle();
      for (int i = 800; i < 804; i++) expect_px(i, 8'h77, "R8 dropped trigger no write");
      expect_px(779, 8'h09, "R8 first run intact");
      bus_write(810, 1, fill_word(1));
      wait_run(1, "R8 engine usable after drop");
      check(err === 1'b1, "R8 err sticky", int'(err), 1);
   endtask

   task automatic t_out_of_range();
      for (int i = 0; i < 4; i++) px_write(i, 8'h99);
      bus_write(0, 0, 32'h0000_003C);
      bus_write(1020, 1, fill_word(8));
      wait_run(8, "R9 edge fill duration");
      expect_px(1020, 8'h3C, "R9 edge in range");
      expect_px(1023, 8'h3C, "R9 edge last");
      for (int i = 0; i < 4; i++) expect_px(i, 8'h99, "R9 no wrap");
      px_write(10, 8'h5E);
      bus_write(32'h80000 + 10, 1, fill_word(3));
      wait_run(3, "R9 far dst duration");
      expect_px(10, 8'h5E, "R9 far dst no write");
      px_write(1022, 8'hAB);
      px_write(1023, 8'hCD);
      bus_write(900, 1, copy_word(1022, 4));
      wait_run(8, "R9 src edge duration");
      expect_px(900, 8'hAB, "R9 src in range");
      expect_px(901, 8'hCD, "R9 src last");
      expect_px(902, 8'h00, "R9 src beyond reads 0");
      expect_px(903, 8'h00, "R9 src beyond reads 0");
   endtask

   task automatic t_reads();
      @(negedge clk);
      bus_rd = 1; bus_addr = 23'h0004;
      #1 check(bus_rdata === 32'h0, "R5 read idle", int'(bus_rdata), 0);
      @(negedge clk);
      bus_rd = 0;
      bus_write(40, 1, fill_word(6));
      bus_rd = 1; bus_addr = 23'h0000;
      #1 check(bus_rdata === 32'h0, "R5 read busy", int'(bus_rdata), 0);
      @(negedge clk);
      bus_rd = 0;
      wait_idle();
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pixel_port();
      t_colour_only();
      t_fill_basic();
      t_fill_lengths();
      t_copy();
      t_overlap();
      t_colour_during_run();
      t_out_of_range();
      t_reads();
      t_drop_trigger();
      report();
   end
endmodule